// File: doc/BRIEF.md
# DRAM Refresh Row-Address Extender

A video controller that refreshes memory with an 8-bit internal row counter leaves any DRAM that needs 512 or more refresh rows partly unrefreshed. This block closes that gap by supplying the missing high-order row bits from a counter of its own. It watches the active-low bus-available line. That line drops just before each raster line's refresh and fetch burst. The first five strobed cycles after the drop are the refresh reads, and during them the block drives its counter onto the bits above bit 7. After those five cycles the normal video page bits return, so that the character and sprite fetches that follow read the right data.

The low eight row bits always pass straight through, because the controller's own counter already cycles them. The block counts refresh reads inside each window. Each time the low row has covered all 256 values, the extension counter steps by one. Across successive passes, every combination of upper and lower rows is therefore visited. The extension width is a parameter: 1 bit for 9-bit refresh, 2 bits for 10-bit refresh, and so on.

Top module: `dram_row_ext`

## Requirements
- R1: `row_out[7:0]` always equals `row_lo` in the same cycle, whether or not the window is open.
- R2: The refresh window opens in the first cycle that `ba_n` is 0 after a cycle in which it was 1. A low level that has not been preceded by a high cycle since reset never opens it.
- R3: While `ba_n` stays 0, the window stays open until five cycles with `cyc_stb` = 1 have been counted. The cycle that carries the fifth strobe is the last window cycle. A long low period never reopens the window.
- R4: A cycle with `ba_n` = 1 closes the window in that same cycle and clears the window count, so the next low level starts a fresh window of five.
- R5: `rfsh_win` is 1 exactly in window cycles. In those cycles `row_out[8 +: EXT_W]` equals the extension counter. In all other cycles it equals `page_hi`.
- R6: The extension counter advances by one after every 256 strobed window cycles, and wraps modulo 2^EXT_W.
- R7: Synchronous active-high `rst` clears the extension counter, the refresh count and the window count, and leaves the window closed until `ba_n` has been seen high.
- R8: A window cycle with `cyc_stb` = 0 neither counts toward the five-cycle limit nor toward the 256-refresh count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| ba_n | input | 1 | Bus-available, active low |
| cyc_stb | input | 1 | Marks a memory cycle that counts |
| row_lo | input | LO_W (8) | Low row address from the video refresh counter |
| page_hi | input | EXT_W (1) | Normal upper address bits used outside the window |
| row_out | output | LO_W+EXT_W (9) | Extended row address |
| rfsh_win | output | 1 | High while the extension bits are driven |

## Verification
`rfsh_win` and the whole of `row_out` are combinational on the current `ba_n`, `row_lo` and `page_hi`, so they are due in the same cycle as the stimulus. The bench drives inputs 1 ns after a rising edge and samples 2 ns later, before the next edge. The window count and the refresh count register at the edge that ends a strobed window cycle, so their effect first shows one cycle later: a sixth low cycle stays closed, and the extension bits hold their new value from the window cycle after the 256th refresh. The bench keeps its own tally of refreshes and window slots and compares each sampled cycle against it.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
   typedef enum logic {
      ARM_WAIT = 1'b0,
      ARM_SET  = 1'b1
   } arm_e;

   function automatic int slot_width(input int slots);
      return $clog2(slots + 1);
   endfunction
endpackage

// File: rtl/rfx_window.sv
module rfx_window
   import rfx_pkg::*;
#(
   parameter int SLOTS = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic ba_n,
   input  logic cyc_stb,
   output logic win,
   output logic win_tick
);
   localparam int SW = slot_width(SLOTS);
   localparam logic [SW-1:0] LIMIT = SW'(SLOTS);

   arm_e          arm_q;
   logic [SW-1:0] slot_q;

   assign win      = !ba_n && (arm_q == ARM_SET) && (slot_q < LIMIT);
   assign win_tick = win && cyc_stb;

   always_ff @(posedge clk) begin
      if (rst) begin
         arm_q  <= ARM_WAIT;
         slot_q <= '0;
      end else if (ba_n) begin
         arm_q  <= ARM_SET;
         slot_q <= '0;
      end else if (win_tick) begin
         slot_q <= slot_q + 1'b1;
      end
   end
endmodule

// File: rtl/rfx_extcnt.sv
module rfx_extcnt #(
   parameter int LO_W  = 8,
   parameter int EXT_W = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [EXT_W-1:0] ext
);
   localparam logic [LO_W-1:0] PASS_END = '1;

   logic [LO_W-1:0]  pass_q;
   logic [EXT_W-1:0] ext_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pass_q <= '0;
         ext_q  <= '0;
      end else if (tick) begin
         pass_q <= pass_q + 1'b1;
         if (pass_q == PASS_END) begin
            ext_q <= ext_q + 1'b1;
         end
      end
   end

   assign ext = ext_q;
endmodule

// File: rtl/rfx_mux.sv
module rfx_mux #(
   parameter int EXT_W = 1
) (
   input  logic             sel,
   input  logic [EXT_W-1:0] ext,
   input  logic [EXT_W-1:0] page,
   output logic [EXT_W-1:0] hi
);
   for (genvar i = 0; i < EXT_W; i++) begin : g_bit
      assign hi[i] = sel ? ext[i] : page[i];
   end
endmodule

// File: rtl/dram_row_ext.sv
module dram_row_ext #(
   parameter int LO_W  = 8,
   parameter int EXT_W = 1,
   parameter int SLOTS = 5
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  ba_n,
   input  logic                  cyc_stb,
   input  logic [LO_W-1:0]       row_lo,
   input  logic [EXT_W-1:0]      page_hi,
   output logic [LO_W+EXT_W-1:0] row_out,
   output logic                  rfsh_win
);
   localparam int OUT_W = LO_W + EXT_W;

   if (LO_W < 1 || LO_W > 16) begin : g_bad_lo
      $error("dram_row_ext: LO_W out of range");
   end
   if (EXT_W < 1 || EXT_W > 8) begin : g_bad_ext
      $error("dram_row_ext: EXT_W out of range");
   end
   if (SLOTS < 1 || SLOTS > 64) begin : g_bad_slots
      $error("dram_row_ext: SLOTS out of range");
   end

   logic             win;
   logic             tick;
   logic [EXT_W-1:0] ext;
   logic [EXT_W-1:0] hi;

   rfx_window #(.SLOTS(SLOTS)) u_win (
      .clk      (clk),
      .rst      (rst),
      .ba_n     (ba_n),
      .cyc_stb  (cyc_stb),
      .win      (win),
      .win_tick (tick)
   );

   rfx_extcnt #(.LO_W(LO_W), .EXT_W(EXT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .ext  (ext)
   );

   rfx_mux #(.EXT_W(EXT_W)) u_mux (
      .sel  (win),
      .ext  (ext),
      .page (page_hi),
      .hi   (hi)
   );

   assign row_out  = OUT_W'({hi, row_lo});
   assign rfsh_win = win;
endmodule

// File: rtl/rfx_chk.sv
module rfx_chk #(
   parameter int LO_W  = 8,
   parameter int EXT_W = 1,
   parameter int SLOTS = 5
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  ba_n,
   input logic                  cyc_stb,
   input logic [LO_W-1:0]       row_lo,
   input logic [EXT_W-1:0]      page_hi,
   input logic [LO_W+EXT_W-1:0] row_out,
   input logic                  rfsh_win
);
   int chk_slots;

   always_ff @(posedge clk) begin
      if (rst || ba_n) chk_slots <= 0;
      else if (rfsh_win && cyc_stb) chk_slots <= chk_slots + 1;
   end

   // R1
   a_r1_low_pass: assert property (@(posedge clk) disable iff (rst)
      row_out[LO_W-1:0] == row_lo);
   // R3
   a_r3_slot_limit: assert property (@(posedge clk) disable iff (rst)
      rfsh_win |-> chk_slots < SLOTS);
   // R4
   a_r4_high_closes: assert property (@(posedge clk) disable iff (rst)
      ba_n |-> !rfsh_win);
   // R2
   a_r2_fall_opens: assert property (@(posedge clk) disable iff (rst)
      ($fell(ba_n) && !$past(rst)) |-> rfsh_win);
   // R5
   a_r5_page_outside: assert property (@(posedge clk) disable iff (rst)
      !rfsh_win |-> row_out[LO_W +: EXT_W] == page_hi);
endmodule

bind dram_row_ext rfx_chk #(.LO_W(LO_W), .EXT_W(EXT_W), .SLOTS(SLOTS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ba_n     (ba_n),
   .cyc_stb  (cyc_stb),
   .row_lo   (row_lo),
   .page_hi  (page_hi),
   .row_out  (row_out),
   .rfsh_win (rfsh_win)
);

// File: tb/tb_dram_row_ext.sv
module tb_dram_row_ext;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ba_n = 1'b1;
   logic       cyc_stb = 1'b0;
   logic [7:0] row_lo = 8'h00;
   logic [0:0] page_hi = 1'b0;
   logic [8:0] row_out;
   logic       rfsh_win;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   bit m_armed;
   int m_slot;
   int m_ref;

   always #2 clk = ~clk;

   dram_row_ext dut (
      .clk(clk), .rst(rst), .ba_n(ba_n), .cyc_stb(cyc_stb),
      .row_lo(row_lo), .page_hi(page_hi), .row_out(row_out), .rfsh_win(rfsh_win)
   );

   // table entry: {ba_n, cyc_stb, expected window}
   localparam logic [2:0] VEC [13] = '{
      3'b110, 3'b011, 3'b001, 3'b011, 3'b011, 3'b011, 3'b011,
      3'b010, 3'b010, 3'b110, 3'b011, 3'b110, 3'b001
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drives one cycle at posedge+1, samples at posedge+3, advances model
   task automatic step(input logic ba, input logic stb, input logic [7:0] lo,
                       input logic hi, input int tab_win);
      bit ew;
      int eu;
      ba_n = ba; cyc_stb = stb; row_lo = lo; page_hi = hi;
      #2;
      ew = !ba && m_armed && (m_slot < 5);
      eu = ew ? ((m_ref / 256) % 2) : int'(hi);
      if (tab_win >= 0) chk("R3 table window", int'(rfsh_win), tab_win);
      chk("R2 window flag", int'(rfsh_win), int'(ew));
      chk("R1 low bits", int'(row_out[7:0]), int'(lo));
      chk("R5 upper bits", int'(row_out[8]), eu);
      if (ba) begin
         m_armed = 1; m_slot = 0;
      end else if (ew && stb) begin
         m_slot++; m_ref++;
      end
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      m_armed = 0; m_slot = 0; m_ref = 0;
      rst = 1; ba_n = 1'b0;
      repeat (2) @(posedge clk);
      #3;
      chk("R7 reset closed", int'(rfsh_win), 0);
      chk("R7 reset page", int'(row_out[8]), int'(page_hi));
      @(posedge clk); #1;
      rst = 0;
      // R7: low held since reset does not open the window
      step(1'b0, 1'b1, 8'h3c, 1'b1, 0);
      step(1'b0, 1'b1, 8'h3d, 1'b1, 0);

      // vector table: R2 R3 R4 R8 with page_hi=1, extension 0
      for (int i = 0; i < 13; i++) begin
         step(VEC[i][2], VEC[i][1], 8'(i * 17 + 3), 1'b1, int'(VEC[i][0]));
      end
      chk("R8 refresh tally", m_ref, 6);

      // R6: run windows until 256 refreshes, then extension bit must read 1
      while (m_ref < 256) begin
         step(1'b1, 1'b1, 8'(m_ref), 1'b0, 0);
         for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b1, 8'(m_ref), 1'b0, (m_ref < 256 || m_slot < 5) ? -1 : -1);
         end
      end
      step(1'b1, 1'b1, 8'h11, 1'b0, 0);
      step(1'b0, 1'b1, 8'h22, 1'b0, 1);
      chk("R6 extension advanced", int'(row_out[8]), 1);
      step(1'b0, 1'b0, 8'h23, 1'b0, 1);
      chk("R6 extension still set", int'(row_out[8]), 1);

      // R7: reset mid-window clears the extension counter
      rst = 1; ba_n = 1'b0;
      @(posedge clk); #1;
      rst = 0;
      m_armed = 0; m_slot = 0; m_ref = 0;
      step(1'b0, 1'b1, 8'h44, 1'b1, 0);
      step(1'b1, 1'b1, 8'h45, 1'b1, 0);
      step(1'b0, 1'b1, 8'h46, 1'b1, 1);
      chk("R7 extension cleared", int'(row_out[8]), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule